// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block sits between a 12-bit parallel sample stream and the switch array of a hybrid segmented current-steering converter. On each rising clock edge it captures a sample and splits it into three tiers. The top five bits become a 31-line unary (thermometer) code for the coarse equal-weight segments. The next four bits become a 15-line unary code for the middle segments, each worth one sixteenth of a coarse segment. The lowest three bits pass through unchanged as controls for the binary-weighted fine elements.

Every control line comes out of a register as a true/complement pair. A differential switch then has two matched drive signals: the true line steers its element to output A and the complement line steers it to output B. A second register stage after the decoder makes all pairs change on the same edge, so the sample-to-switch latency is two clock cycles.

Top module: `seg_dac_decoder`

## Requirements
- R1: The coarse field is input bits [11:7], with value k in 0..31. After decoding, coarse true lines 0 to k-1 are high and lines k to 30 are low.
- R2: The middle field is input bits [6:3], with value m in 0..15. After decoding, middle true lines 0 to m-1 are high and lines m to 14 are low.
- R3: The fine true lines [2:0] equal input bits [2:0] without decoding. Line i carries weight 2^i.
- R4: On every cycle, each complement output is the bitwise inverse of its true output.
- R5: A synchronous active-high reset clears both register stages. While reset is held, all true lines are low and all complement lines are high. The first output edge after release still shows the cleared state.
- R6: A sample present at the edge at cycle n appears on every true and complement line after the edge at cycle n+1, which is two register stages. All lines update on that same edge.
- R7: Input 0x000 gives all true lines low. Input 0xFFF gives all 31 coarse, all 15 middle and all 3 fine true lines high.
- R8: For every one of the 4096 input codes, (coarse count × 16 + middle count) × 8 + fine value equals the input code. Here coarse count and middle count are the numbers of high true lines in each tier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| data_i | input | 12 | Parallel input sample |
| msb_t_o | output | 31 | Coarse segment true lines (steer to A) |
| msb_c_o | output | 31 | Coarse segment complement lines (steer to B) |
| mid_t_o | output | 15 | Middle segment true lines |
| mid_c_o | output | 15 | Middle segment complement lines |
| lsb_t_o | output | 3 | Fine binary element true lines |
| lsb_c_o | output | 3 | Fine binary element complement lines |

## Verification
A wrong captured sample or a faulty decode shows two edges later. It appears as a thermometer with a gap or the wrong fill count, or as a weighted sum that differs from the code driven two cycles earlier. The bench therefore compares every cycle against a two-deep history of its own stimulus. A complement register out of step with its true register breaks the inverse relation on the very cycle it happens. A reset that clears only one stage leaks a stale code onto the first output edge after release. The bench checks that edge directly.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;

    // Tier widths; their order in the input word is fixed by weight
    localparam int unsigned MSB_BITS  = 5;
    localparam int unsigned MID_BITS  = 4;
    localparam int unsigned LSB_BITS  = 3;
    localparam int unsigned DATA_W    = MSB_BITS + MID_BITS + LSB_BITS;

    localparam int unsigned MSB_LINES = (1 << MSB_BITS) - 1;
    localparam int unsigned MID_LINES = (1 << MID_BITS) - 1;
    localparam int unsigned CTRL_W    = MSB_LINES + MID_LINES + LSB_BITS;

    // Captured sample, coarse field in the top bits
    typedef struct packed {
        logic [MSB_BITS-1:0] msb;
        logic [MID_BITS-1:0] mid;
        logic [LSB_BITS-1:0] lsb;
    } sample_t;

    // Decoded switch controls for one polarity
    typedef struct packed {
        logic [MSB_LINES-1:0] msb;
        logic [MID_LINES-1:0] mid;
        logic [LSB_BITS-1:0]  lsb;
    } ctrl_t;

    function automatic sample_t split_word(input logic [DATA_W-1:0] w);
        return sample_t'(w);
    endfunction

endpackage

// File: rtl/seg_dac_in_reg.sv
module seg_dac_in_reg
    import seg_dac_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [DATA_W-1:0]   data_i,
    output sample_t             smp_q
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            smp_q <= '0;
        end else begin
            smp_q <= split_word(data_i);
        end
    end

endmodule

// File: rtl/seg_dac_thermo.sv
module seg_dac_thermo #(
    parameter int unsigned IN_W  = 5,
    localparam int unsigned LINES = (1 << IN_W) - 1
) (
    input  logic [IN_W-1:0]   code_i,
    output logic [LINES-1:0]  line_o
);

    // Line i is on when the code exceeds i: fill from index 0 upward
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign line_o[i] = (32'(code_i) > i);
    end

    // R1, R2: no gaps in the thermometer and the count matches the code
    always_comb begin
        if (!$isunknown(code_i)) begin
            assert_thermo_shape_R1: assert ((line_o & (line_o + LINES'(1))) == '0)
                else $error("thermometer has a gap");
            assert_thermo_count_R2: assert ($countones(line_o) == 32'(code_i))
                else $error("thermometer count differs from code");
        end
    end

endmodule

// File: rtl/seg_dac_out_reg.sv
module seg_dac_out_reg
    import seg_dac_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [CTRL_W-1:0]  ctrl_d,
    output logic [CTRL_W-1:0]  true_q,
    output logic [CTRL_W-1:0]  comp_q
);

    // Separate flops per polarity so both drive lines switch on one edge
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            true_q <= '0;
            comp_q <= '1;
        end else begin
            true_q <= ctrl_d;
            comp_q <= ~ctrl_d;
        end
    end

    assert_comp_inverse_R4: assert property (@(posedge clk_i)
        disable iff (rst_i) comp_q == ~true_q)
        else $error("complement out of step with true lines");

    assert_reset_clear_R5: assert property (@(posedge clk_i)
        rst_i |=> (true_q == '0) && (comp_q == '1))
        else $error("outputs not cleared by reset");

endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
    import seg_dac_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [DATA_W-1:0]     data_i,
    output logic [MSB_LINES-1:0]  msb_t_o,
    output logic [MSB_LINES-1:0]  msb_c_o,
    output logic [MID_LINES-1:0]  mid_t_o,
    output logic [MID_LINES-1:0]  mid_c_o,
    output logic [LSB_BITS-1:0]   lsb_t_o,
    output logic [LSB_BITS-1:0]   lsb_c_o
);

    sample_t              smp_q;
    logic [MSB_LINES-1:0] msb_dec;
    logic [MID_LINES-1:0] mid_dec;
    ctrl_t                ctrl_d;
    ctrl_t                true_q;
    ctrl_t                comp_q;

    seg_dac_in_reg u_in_reg (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .data_i (data_i),
        .smp_q  (smp_q)
    );

    seg_dac_thermo #(.IN_W(MSB_BITS)) u_msb_thermo (
        .code_i (smp_q.msb),
        .line_o (msb_dec)
    );

    seg_dac_thermo #(.IN_W(MID_BITS)) u_mid_thermo (
        .code_i (smp_q.mid),
        .line_o (mid_dec)
    );

    always_comb begin
        ctrl_d.msb = msb_dec;
        ctrl_d.mid = mid_dec;
        ctrl_d.lsb = smp_q.lsb;
    end

    seg_dac_out_reg u_out_reg (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ctrl_d (ctrl_d),
        .true_q (true_q),
        .comp_q (comp_q)
    );

    assign msb_t_o = true_q.msb;
    assign msb_c_o = comp_q.msb;
    assign mid_t_o = true_q.mid;
    assign mid_c_o = comp_q.mid;
    assign lsb_t_o = true_q.lsb;
    assign lsb_c_o = comp_q.lsb;

    // R6: outputs follow the captured sample one edge later
    assert_coarse_follow_R6: assert property (@(posedge clk_i)
        disable iff (rst_i) $countones(msb_t_o) == $past(32'(smp_q.msb)))
        else $error("coarse count not one stage behind capture");

    assert_fine_follow_R3: assert property (@(posedge clk_i)
        disable iff (rst_i) lsb_t_o == $past(smp_q.lsb))
        else $error("fine bits not passed through");

endmodule

// File: tb/seg_dac_decoder_tb.sv
module seg_dac_decoder_tb;
    import seg_dac_pkg::*;

    logic                 clk;
    logic                 rst;
    logic [DATA_W-1:0]    data;
    logic [MSB_LINES-1:0] msb_t, msb_c;
    logic [MID_LINES-1:0] mid_t, mid_c;
    logic [LSB_BITS-1:0]  lsb_t, lsb_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [DATA_W-1:0] prev1, prev2;

    seg_dac_decoder u_dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .data_i  (data),
        .msb_t_o (msb_t),
        .msb_c_o (msb_c),
        .mid_t_o (mid_t),
        .mid_c_o (mid_c),
        .lsb_t_o (lsb_t),
        .lsb_c_o (lsb_c)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [MSB_LINES-1:0] exp_msb(input logic [DATA_W-1:0] v);
        logic [31:0] t = (32'h1 << v[11:7]) - 32'h1;
        return t[MSB_LINES-1:0];
    endfunction

    function automatic logic [MID_LINES-1:0] exp_mid(input logic [DATA_W-1:0] v);
        logic [31:0] t = (32'h1 << v[6:3]) - 32'h1;
        return t[MID_LINES-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare the ports with the sample driven two cycles earlier (R6)
    task automatic check_out(input logic [DATA_W-1:0] v);
        int sum;
        chk(msb_t === exp_msb(v), "R1", "coarse thermometer", 64'(msb_t), 64'(exp_msb(v)));
        chk(mid_t === exp_mid(v), "R2", "middle thermometer", 64'(mid_t), 64'(exp_mid(v)));
        chk(lsb_t === v[2:0], "R3", "fine pass-through", 64'(lsb_t), 64'(v[2:0]));
        chk((msb_c === ~msb_t) && (mid_c === ~mid_t) && (lsb_c === ~lsb_t), "R4",
            "complement", {msb_c, mid_c, lsb_c}, ~{msb_t, mid_t, lsb_t});
        sum = ($countones(msb_t) * 16 + $countones(mid_t)) * 8 + int'(lsb_t);
        chk(sum == int'(v), "R8", "weighted sum", 64'(sum), 64'(v));
    endtask

    task automatic step(input logic [DATA_W-1:0] v);
        @(negedge clk);
        check_out(prev2);
        prev2 = prev1;
        prev1 = v;
        data  = v;
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(msb_t === '0 && mid_t === '0 && lsb_t === '0, "R5", "true low in reset",
                64'({msb_t, mid_t, lsb_t}), 64'(0));
            chk(msb_c === '1 && mid_c === '1 && lsb_c === '1, "R5", "complement high in reset",
                64'({msb_c, mid_c, lsb_c}), {15'h0, {CTRL_W{1'b1}}});
        end
        rst   = 1'b0;
        prev2 = '0;       // first edge after release shows the cleared stage (R5)
        prev1 = data;
    endtask

    initial begin
        void'($urandom(32'd1357));
        rst  = 1'b1;
        data = '0;
        prev1 = '0;
        prev2 = '0;
        do_reset(3);

        // R7: extremes
        step(12'h000);
        step(12'hFFF);
        step(12'h000);
        step(12'hFFF);
        step(12'h07F);
        step(12'hF80);
        step(12'h001);
        step(12'h800);

        // R5: reset with a full-scale code in both stages
        step(12'hFFF);
        step(12'hFFF);
        data = 12'hABC;
        do_reset(2);
        step(12'h555);
        step(12'hAAA);

        // R8: every code, ascending
        for (int c = 0; c < 4096; c++) step(DATA_W'(c));

        // Random mix
        for (int n = 0; n < 600; n++) step(DATA_W'($urandom));

        // Drain and final R7 extremes
        step(12'hFFF);
        step(12'h000);
        step(12'h000);
        step(12'h000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule